// File: doc/BRIEF.md
# Power-Down and Clock-Reset Controller

This block decides which parts of a mixed-signal audio device may be powered and clocked. It watches an asynchronous active-low power-down pin and two asynchronous regulator fault flags (overcurrent and overvoltage). It holds the clock-release control bit, and it drives enables for the regulator and reference, for the PLL and internal clocks, and for the converter blocks. A ready flag tells the register front end when configuration writes may be accepted.

The device has four states. While the pin is low, everything is off. When the pin is high and the clock-release bit is clear, the regulator and reference run but clocks and converters are held. When the pin is high and the bit is set, everything runs. A regulator fault forces a latched shutdown that only a low-then-high cycle of the pin can leave.

After every synchronized rising edge of the pin, a cycle counter sized from the reference clock frequency measures a 1 ms settling window. The ready flag stays low until that window has passed. Writes to the clock-release bit are dropped while the flag is low.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and directly after synchronous reset, `pwr_state` is 0 and `ldo_ref_en`, `clk_run_en`, `conv_en`, `cfg_ready` and `ckrel_q` are all 0.
- R2: Whenever the synchronized pin is low, the block goes to power-down (`pwr_state` = 0) with every enable, `cfg_ready` and `ckrel_q` at 0, whatever the clock-release bit was. This holds even from the run state.
- R3: A rising pin edge moves power-down to clock reset (`pwr_state` = 1) on the third clock edge after the pin changes (two synchronizer flops plus the state register). In clock reset `ldo_ref_en` is 1 and `clk_run_en` and `conv_en` are 0.
- R4: `cfg_ready` rises on clock edge WAIT+4 after the pin goes high and is 0 on edge WAIT+3, where WAIT = (CLK_HZ/1000)·WAIT_MS cycles. It is only ever 1 in states 1 or 2.
- R5: A write to the clock-release bit while `cfg_ready` is 0 is ignored: `ckrel_q` stays 0 and the state stays at clock reset.
- R6: A write of 1 while `cfg_ready` is 1 sets `ckrel_q` on that edge. On the next edge the state becomes run (`pwr_state` = 2) with `ldo_ref_en`, `clk_run_en` and `conv_en` all 1.
- R7: A write of 0 in run clears `ckrel_q`. One edge later the state returns to clock reset, with clocks and converters off and `cfg_ready` still 1.
- R8: If either fault flag (overcurrent or overvoltage) is high while the pin is high, the block enters the fault state (`pwr_state` = 3) on the third edge. In that state every enable, `cfg_ready` and `ckrel_q` are 0.
- R9: The fault state persists after the fault flags clear for as long as the pin stays high. Pin low leads to power-down.
- R10: Each new rising pin edge restarts the settling window. A one-cycle low pulse during the window delays `cfg_ready` to WAIT+4 edges after the second rise.
- R11: After leaving power-down or fault, `ckrel_q` is 0. A new pin rise therefore lands in clock reset, not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n_pin | input | 1 | Asynchronous active-low power-down pin |
| ocp_flag | input | 1 | Asynchronous regulator overcurrent flag |
| ovp_flag | input | 1 | Asynchronous regulator overvoltage flag |
| ckrel_wr | input | 1 | Write strobe for the clock-release bit |
| ckrel_wdata | input | 1 | Value written to the clock-release bit |
| ldo_ref_en | output | 1 | Enable for the internal regulator and reference |
| clk_run_en | output | 1 | Enable for the PLL and internal clocks |
| conv_en | output | 1 | Enable for the ADC and DAC blocks |
| cfg_ready | output | 1 | Configuration writes accepted |
| ckrel_q | output | 1 | Current clock-release bit |
| pwr_state | output | 2 | 0 power-down, 1 clock reset, 2 run, 3 fault latched |

## Verification
A table of pin, fault and write patterns walks the block through every state. It checks that writes during the settling window leave the clock-release bit alone, that the bit toggles between run and clock reset once ready, and that overcurrent and overvoltage each latch the fault and survive their own release. Directed patterns then pin down the exact edge on which ready rises, which separates an early or late counter from a correct one. A one-cycle pin glitch inside the window shows whether the count truly restarts. A pin drop from run shows that the release bit is cleared rather than remembered.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_PD    = 2'd0,
    ST_CKRST = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_sync.sv
// Multi-bit, multi-stage synchronizer; every bit is an independent level.
module pwr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_wait_timer.sv
// Saturating settling counter: restarts on clear, stops at WAIT_CYC.
module pwr_wait_timer #(
  parameter int unsigned WAIT_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic done
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned WAIT_MS     = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pdn_n_pin,
  input  logic       ocp_flag,
  input  logic       ovp_flag,
  input  logic       ckrel_wr,
  input  logic       ckrel_wdata,
  output logic       ldo_ref_en,
  output logic       clk_run_en,
  output logic       conv_en,
  output logic       cfg_ready,
  output logic       ckrel_q,
  output logic [1:0] pwr_state
);
  localparam int unsigned WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;

  logic [2:0] raw_in, sync_out;
  logic       pin_s, pin_d, pin_rise, flt_s, tmr_clear, tmr_done, on_n;
  pwr_state_e state_q, state_n;

  assign raw_in = {ovp_flag, ocp_flag, pdn_n_pin};

  pwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign pin_s = sync_out[0];
  assign flt_s = sync_out[1] | sync_out[2];

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end
  assign pin_rise = pin_s & ~pin_d;

  assign tmr_clear = ~pin_s | pin_rise | (state_q == ST_FAULT);

  pwr_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear(tmr_clear), .done(tmr_done)
  );

  always_comb begin
    state_n = state_q;
    if (!pin_s)     state_n = ST_PD;
    else if (flt_s) state_n = ST_FAULT;
    else begin
      case (state_q)
        ST_PD:    if (pin_rise) state_n = ST_CKRST;
        ST_CKRST: if (ckrel_q)  state_n = ST_RUN;
        ST_RUN:   if (!ckrel_q) state_n = ST_CKRST;
        default:  state_n = ST_FAULT;
      endcase
    end
  end

  assign on_n = (state_n == ST_CKRST) || (state_n == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_PD;
      ldo_ref_en <= 1'b0;
      clk_run_en <= 1'b0;
      conv_en    <= 1'b0;
      cfg_ready  <= 1'b0;
      ckrel_q    <= 1'b0;
    end else begin
      state_q    <= state_n;
      ldo_ref_en <= on_n;
      clk_run_en <= (state_n == ST_RUN);
      conv_en    <= (state_n == ST_RUN);
      cfg_ready  <= on_n && tmr_done;
      if (!on_n)                      ckrel_q <= 1'b0;
      else if (ckrel_wr && cfg_ready) ckrel_q <= ckrel_wdata;
    end
  end

  assign pwr_state = state_q;

  // R2
  pd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_s |=> state_q == ST_PD);
  // R8
  fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_s && flt_s) |=> state_q == ST_FAULT);
  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAULT && pin_s) |=> state_q == ST_FAULT);
  // R5
  ckrel_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ready && !ckrel_q) |=> !ckrel_q);
  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    clk_run_en |-> ldo_ref_en);
  // R4
  ready_state_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |-> (state_q == ST_CKRST || state_q == ST_RUN));
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int unsigned CLK_HZ = 16000;
  localparam int unsigned W      = CLK_HZ / 1000;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst, pin, oc, ov, wr, wd;
  logic ldo, pll, conv, rdy, ck;
  logic [1:0] st;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .pdn_n_pin(pin), .ocp_flag(oc), .ovp_flag(ov),
    .ckrel_wr(wr), .ckrel_wdata(wd), .ldo_ref_en(ldo), .clk_run_en(pll),
    .conv_en(conv), .cfg_ready(rdy), .ckrel_q(ck), .pwr_state(st)
  );

  // Entry: req[4], pin, oc, ov, wr, wd, hold[6], st[2], ldo, pll, rdy, ck
  localparam logic [20:0] VEC [NV] = '{
    {4'd2,  5'b00000, 6'd5,  2'd0, 4'b0000},  // R2 idle low
    {4'd3,  5'b10000, 6'd3,  2'd1, 4'b1000},  // R3 rise
    {4'd5,  5'b10011, 6'd4,  2'd1, 4'b1000},  // R5 early write dropped
    {4'd4,  5'b10000, 6'd16, 2'd1, 4'b1010},  // R4 ready after window
    {4'd6,  5'b10011, 6'd2,  2'd2, 4'b1111},  // R6 run
    {4'd7,  5'b10010, 6'd2,  2'd1, 4'b1010},  // R7 back to clock reset
    {4'd6,  5'b10011, 6'd2,  2'd2, 4'b1111},  // R6 run again
    {4'd8,  5'b11000, 6'd3,  2'd3, 4'b0000},  // R8 overcurrent
    {4'd9,  5'b10000, 6'd6,  2'd3, 4'b0000},  // R9 latched
    {4'd9,  5'b00000, 6'd3,  2'd0, 4'b0000},  // R9 pin low exits
    {4'd11, 5'b10000, 6'd3,  2'd1, 4'b1000},  // R11 lands in clock reset
    {4'd11, 5'b10000, 6'd20, 2'd1, 4'b1010},  // R11 bit still clear
    {4'd8,  5'b10100, 6'd3,  2'd3, 4'b0000},  // R8 overvoltage
    {4'd9,  5'b10000, 6'd3,  2'd3, 4'b0000},  // R9 latched
    {4'd2,  5'b00000, 6'd3,  2'd0, 4'b0000},  // R2
    {4'd4,  5'b10000, 6'd24, 2'd1, 4'b1010},  // R4
    {4'd6,  5'b10011, 6'd2,  2'd2, 4'b1111},  // R6
    {4'd2,  5'b00000, 6'd3,  2'd0, 4'b0000},  // R2 from run
    {4'd11, 5'b10000, 6'd3,  2'd1, 4'b1000}   // R11
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; pin = 1'b0; oc = 1'b0; ov = 1'b0; wr = 1'b0; wd = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", st, 0);
    chk("R1 enables", {ldo, pll, conv, rdy, ck}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {st, ldo, pll, conv, rdy, ck}, 0);

    for (int i = 0; i < NV; i++) begin
      {pin, oc, ov, wr, wd} = VEC[i][16:12];
      repeat (int'(VEC[i][11:6])) @(negedge clk);
      chk($sformatf("R%0d vec%0d state", VEC[i][20:17], i), st, int'(VEC[i][5:4]));
      chk($sformatf("R%0d vec%0d outs", VEC[i][20:17], i),
          {ldo, pll, conv, rdy, ck},
          {VEC[i][3], VEC[i][2], VEC[i][2], VEC[i][1], VEC[i][0]});
    end
    wr = 1'b0; wd = 1'b0;

    // R4 exact ready edge
    pin = 1'b0;
    repeat (4) @(negedge clk);
    pin = 1'b1;
    repeat (W + 3) @(negedge clk);
    chk("R4 ready one edge early", rdy, 0);
    @(negedge clk);
    chk("R4 ready on edge", rdy, 1);

    // R10 glitch restarts the window
    pin = 1'b0;
    repeat (4) @(negedge clk);
    pin = 1'b1;
    repeat (10) @(negedge clk);
    pin = 1'b0;
    @(negedge clk);
    pin = 1'b1;
    repeat (W + 3) @(negedge clk);
    chk("R10 ready held after restart", rdy, 0);
    chk("R10 state", st, 1);
    @(negedge clk);
    chk("R10 ready after second window", rdy, 1);

    finish_run();
  end
endmodule